// File: doc/BRIEF.md
# Differential Arithmetic Self-Test Controller

This block is an on-chip harness that checks one 32-bit floating-point arithmetic unit against a second, functionally equivalent one. A rising edge on `start` begins a run. The block then produces a long stream of pseudo-random operand pairs and drives each pair to both units at once through a single shared operand bus. It tracks every issued pair through a valid shift register whose depth matches the units' pipeline latency. This lets each pair of results be compared against the vector that produced them.

The operands come from two lanes of a small twisted-feedback (Mersenne-Twister-family) generator, and the generator state is loaded from a seed parameter at reset. The same seed therefore always gives the same stimulus. Results are compared bit for bit, with one exception: two NaNs are treated as equal whatever their sign or payload. The first mismatch latches a sticky failure. Progress is shown on four status outputs. A test-only input corrupts the unit-under-test result, so that the failure path itself can be checked.

Top module: `stc_selftest`

## Requirements
- R1: While `rst` is high, and after it falls until a start edge arrives, `test_running`, `test_done`, `test_pass`, `test_fail` and `op_valid` are all low.
- R2: A low-to-high transition of `start` seen in the idle state makes `test_running` high from the next clock edge. A `start` held high does not restart the run, and toggling `start` during a run has no effect on the number of vectors issued.
- R3: A run issues exactly NUM_VECTORS vectors. `op_valid` is high for NUM_VECTORS consecutive cycles, starting in the cycle right after the edge that sampled the start edge, and is never high outside a run.
- R4: Counting the edge that samples the start edge as edge 0, `test_running` falls and `test_done` rises together at edge NUM_VECTORS+LATENCY+1.
- R5: The results for vector k (k = 1 for the first vector) are compared LATENCY cycles after it is issued. A mismatch on vector k raises `test_fail` at edge k+LATENCY, and not earlier.
- R6: Results match only when all 32 bits are equal, except that two NaNs always match. A word is a NaN when bits 30..23 are all ones and bits 22..0 are not all zero. An infinity (mantissa zero) never matches a NaN.
- R7: `test_fail` stays high until reset once it has risen. `test_pass` is high only in the done state, and only when `test_fail` is low.
- R8: Operands are generated from the SEED parameter alone, so every run after a reset produces the same sequence. The two operands of a vector come from different lanes and differ from each other, and consecutive vectors differ.
- R9: While `inject_err` is high during a comparison cycle, bit 30 of the unit-under-test result is inverted before the comparison. This always produces a mismatch.
- R10: The done state holds until reset. A new start edge in the done state is ignored, and `op_valid` stays low.
- R11: `test_running` and `test_done` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns to idle and clears all status |
| start | input | 1 | Begins a run on a rising edge while idle |
| inject_err | input | 1 | Test-only: flips bit 30 of the unit-under-test result before comparison |
| op_valid | output | 1 | A new operand pair is presented to both units this cycle |
| op_a | output | 32 | First operand, shared by both units |
| op_b | output | 32 | Second operand, shared by both units |
| uut_res | input | 32 | Result of the unit under test, LATENCY cycles after issue |
| ref_res | input | 32 | Result of the reference unit, LATENCY cycles after issue |
| test_running | output | 1 | A run is in progress |
| test_done | output | 1 | The run has finished |
| test_pass | output | 1 | Finished with no mismatch |
| test_fail | output | 1 | At least one mismatch seen (sticky) |

## Verification
Edge 0 is the edge that samples the start edge. `test_running` is due just after edge 0. `op_valid` is due for the NUM_VECTORS cycles that follow. A mismatch on vector k is due on `test_fail` just after edge k+LATENCY, and `test_done` with its pass verdict is due just after edge NUM_VECTORS+LATENCY+1. The bench drives inputs and samples outputs on the falling edge, and counts rising edges from edge 0 before each check. It checks `test_fail` low one edge before its due edge and high on that edge, so an early flag and a late flag are both reported. The unit models in the bench are LATENCY-deep register pipelines that can corrupt one chosen vector, produce NaNs with differing payloads, or pit an infinity against a NaN.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef logic [31:0] fp32_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } stc_state_e;

    // Four-word generator state of the twisted-feedback generator
    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [31:0] w3;
    } prng_state_t;

    localparam logic [31:0] PRNG_MAT1 = 32'h8f70_11ee;
    localparam logic [31:0] PRNG_MAT2 = 32'hfc78_ff1f;
    localparam logic [31:0] PRNG_TMAT = 32'h3793_fdff;
    localparam logic [31:0] LANE_SPREAD = 32'h9e37_79b9;
    localparam int unsigned INJECT_BIT = 30;

    function automatic prng_state_t prng_seed(input logic [31:0] seed);
        prng_state_t s;
        s.w0 = seed;
        s.w1 = PRNG_MAT1;
        s.w2 = PRNG_MAT2;
        s.w3 = PRNG_TMAT;
        return s;
    endfunction

    function automatic prng_state_t prng_next(input prng_state_t s);
        prng_state_t n;
        logic [31:0] x;
        logic [31:0] y;
        y = s.w3;
        x = (s.w0 & 32'h7fff_ffff) ^ s.w1 ^ s.w2;
        x = x ^ (x << 1);
        y = y ^ (y >> 1) ^ x;
        n.w0 = s.w1;
        n.w1 = s.w2;
        n.w2 = x ^ (y << 10);
        n.w3 = y;
        if (y[0]) begin
            n.w1 = n.w1 ^ PRNG_MAT1;
            n.w2 = n.w2 ^ PRNG_MAT2;
        end
        return n;
    endfunction

    function automatic fp32_t prng_temper(input prng_state_t s);
        logic [31:0] t0;
        logic [31:0] t1;
        t1 = s.w0 + (s.w2 >> 8);
        t0 = s.w3 ^ t1;
        if (t1[0]) t0 = t0 ^ PRNG_TMAT;
        return t0;
    endfunction

    function automatic logic fp_is_nan(input fp32_t v);
        return (&v[30:23]) && (|v[22:0]);
    endfunction

    function automatic logic fp_results_match(input fp32_t a, input fp32_t b);
        if (fp_is_nan(a) && fp_is_nan(b)) return 1'b1;
        return a == b;
    endfunction

endpackage

// File: rtl/stc_prng.sv
module stc_prng
    import stc_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h1234_5678
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output fp32_t value
);

    prng_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= prng_seed(SEED);
        end else if (advance) begin
            st_q <= prng_next(st_q);
        end
    end

    assign value = prng_temper(st_q);

endmodule

// File: rtl/stc_align.sv
module stc_align #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic due,
    output logic busy
);

    logic [DEPTH-1:0] vld_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) vld_q <= '0;
                else     vld_q <= issue;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) vld_q <= '0;
                else     vld_q <= {vld_q[DEPTH-2:0], issue};
            end
        end
    endgenerate

    assign due  = vld_q[DEPTH-1];
    assign busy = |vld_q;

endmodule

// File: rtl/stc_compare.sv
module stc_compare
    import stc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmp_en,
    input  logic  inject,
    input  fp32_t uut_res,
    input  fp32_t ref_res,
    output logic  fail_q
);

    fp32_t uut_eff;
    logic  mismatch;

    always_comb begin
        uut_eff = uut_res;
        if (inject) uut_eff[INJECT_BIT] = ~uut_res[INJECT_BIT];
        mismatch = cmp_en && !fp_results_match(uut_eff, ref_res);
    end

    always_ff @(posedge clk) begin
        if (rst)           fail_q <= 1'b0;
        else if (mismatch) fail_q <= 1'b1;
    end

endmodule

// File: rtl/stc_selftest.sv
module stc_selftest
    import stc_pkg::*;
#(
    parameter longint unsigned NUM_VECTORS = 64'd4294967296,
    parameter int unsigned     LATENCY     = 4,
    parameter logic [31:0]     SEED        = 32'h1234_5678
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        inject_err,
    output logic        op_valid,
    output logic [31:0] op_a,
    output logic [31:0] op_b,
    input  logic [31:0] uut_res,
    input  logic [31:0] ref_res,
    output logic        test_running,
    output logic        test_done,
    output logic        test_pass,
    output logic        test_fail
);

    localparam int unsigned CNT_W   = $clog2(NUM_VECTORS + 1);
    localparam int unsigned N_LANES = 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_VECTORS);

    stc_state_e       state_q;
    logic             start_q;
    logic [CNT_W-1:0] issued_q;
    logic             issue;
    logic             cmp_due;
    logic             pipe_busy;
    logic             fail_q;
    fp32_t            lane_val [N_LANES];

    assign issue = (state_q == ST_RUN) && (issued_q != LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            start_q  <= 1'b0;
            issued_q <= '0;
        end else begin
            start_q <= start;
            case (state_q)
                ST_IDLE: begin
                    if (start && !start_q) begin
                        state_q  <= ST_RUN;
                        issued_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (issue) issued_q <= issued_q + 1'b1;
                    if (!issue && !pipe_busy) state_q <= ST_DONE;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            stc_prng #(
                .SEED(SEED ^ (LANE_SPREAD * 32'(g)))
            ) u_prng (
                .clk    (clk),
                .rst    (rst),
                .advance(issue),
                .value  (lane_val[g])
            );
        end
    endgenerate

    stc_align #(
        .DEPTH(LATENCY)
    ) u_align (
        .clk  (clk),
        .rst  (rst),
        .issue(issue),
        .due  (cmp_due),
        .busy (pipe_busy)
    );

    stc_compare u_cmp (
        .clk    (clk),
        .rst    (rst),
        .cmp_en (cmp_due),
        .inject (inject_err),
        .uut_res(uut_res),
        .ref_res(ref_res),
        .fail_q (fail_q)
    );

    assign op_valid     = issue;
    assign op_a         = lane_val[0];
    assign op_b         = lane_val[1];
    assign test_running = (state_q == ST_RUN);
    assign test_done    = (state_q == ST_DONE);
    assign test_fail    = fail_q;
    assign test_pass    = (state_q == ST_DONE) && !fail_q;

endmodule

// File: rtl/stc_selftest_chk.sv
module stc_selftest_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic op_valid,
    input logic test_running,
    input logic test_done,
    input logic test_pass,
    input logic test_fail
);

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        test_fail |=> test_fail);

    p_pass_gate_r7: assert property (@(posedge clk) disable iff (rst)
        test_pass |-> (test_done && !test_fail));

    p_run_done_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(test_running && test_done));

    p_valid_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> test_running);

    p_done_holds_r10: assert property (@(posedge clk) disable iff (rst)
        test_done |=> (test_done && !test_running && !op_valid));

    p_run_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(test_running) |-> ($past(start) && !$past(test_done)));

    p_done_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(test_done) |-> $past(test_running));

    p_fail_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(test_fail) |-> test_running);

endmodule

bind stc_selftest stc_selftest_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op_valid    (op_valid),
    .test_running(test_running),
    .test_done   (test_done),
    .test_pass   (test_pass),
    .test_fail   (test_fail)
);

// File: tb/tb_stc_selftest.sv
module tb_stc_selftest;

    localparam int unsigned N   = 20;
    localparam int unsigned LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        inject_err = 1'b0;
    logic        op_valid;
    logic [31:0] op_a, op_b;
    logic [31:0] uut_res, ref_res;
    logic        test_running, test_done, test_pass, test_fail;

    int checks = 0;
    int fails  = 0;

    // Unit model control: 0 equal, 1 NaN pair with differing payloads,
    // 2 corrupt LSB of vector bad_k, 3 infinity vs NaN on vector bad_k
    int mode  = 0;
    int bad_k = 0;
    int vidx  = 0;

    logic [31:0] upipe [LAT];
    logic [31:0] rpipe [LAT];
    logic [31:0] base_v, u_in, r_in;

    always #10 clk = ~clk;

    stc_selftest #(
        .NUM_VECTORS(N),
        .LATENCY    (LAT),
        .SEED       (32'hC0FF_EE11)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .inject_err  (inject_err),
        .op_valid    (op_valid),
        .op_a        (op_a),
        .op_b        (op_b),
        .uut_res     (uut_res),
        .ref_res     (ref_res),
        .test_running(test_running),
        .test_done   (test_done),
        .test_pass   (test_pass),
        .test_fail   (test_fail)
    );

    always_comb begin
        base_v = op_a + op_b;
        u_in   = base_v;
        r_in   = base_v;
        if (mode == 1) begin
            u_in = {1'b0, 8'hFF, base_v[22:1], 1'b1};
            r_in = {1'b1, 8'hFF, ~base_v[22:1], 1'b1};
        end else if (mode == 2 && (vidx + 1) == bad_k) begin
            u_in = base_v ^ 32'h1;
        end else if (mode == 3 && (vidx + 1) == bad_k) begin
            u_in = 32'h7F80_0000;
            r_in = 32'h7F80_0001;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vidx <= 0;
        else if (op_valid) vidx <= vidx + 1;
        upipe[0] <= u_in;
        rpipe[0] <= r_in;
        for (int i = 1; i < LAT; i++) begin
            upipe[i] <= upipe[i-1];
            rpipe[i] <= rpipe[i-1];
        end
    end

    assign uut_res = upipe[LAT-1];
    assign ref_res = rpipe[LAT-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int m, input int k);
        rst = 1'b1;
        start = 1'b0;
        inject_err = 1'b0;
        mode = m;
        bad_k = k;
        step(2);
        rst = 1'b0;
    endtask

    logic [31:0] first_a, first_b, second_a;

    // R1: reset state
    task automatic t_reset;
        rst = 1'b1;
        step(2);
        chk({test_running, test_done, test_pass, test_fail, op_valid} == 5'b0,
            "R1", "status during reset", {test_running, test_done, test_pass, test_fail, op_valid}, 0);
        rst = 1'b0;
        step(3);
        chk({test_running, test_done, test_pass, test_fail, op_valid} == 5'b0,
            "R1", "status idle after reset", {test_running, test_done, test_pass, test_fail, op_valid}, 0);
    endtask

    // R2 R3 R4 R7 R8 R11: clean run, start toggled mid-run
    task automatic t_clean_run;
        int nvalid = 0;
        bit run_ok = 1'b1;
        do_reset(0, 0);
        start = 1'b1;
        step(1);
        chk(test_running == 1'b1, "R2", "running after start edge", test_running, 1);
        first_a = op_a;
        first_b = op_b;
        for (int i = 0; i <= int'(N + LAT); i++) begin
            if (i == 1) second_a = op_a;
            if (i == 5) start = 1'b0;
            if (i == 7) start = 1'b1;
            if (op_valid) begin
                nvalid++;
                if (i >= int'(N)) run_ok = 1'b0;
            end
            if (!test_running || test_done) run_ok = 1'b0;
            if (i < int'(N + LAT)) step(1);
        end
        chk(nvalid == int'(N), "R3", "vector count", nvalid, N);
        chk(run_ok, "R11", "running only, in order, until last compare", run_ok, 1);
        step(1);
        chk(test_done && !test_running, "R4", "done at edge N+LAT+1",
            {test_done, test_running}, 2'b10);
        chk(test_pass && !test_fail, "R7", "pass on clean run", {test_pass, test_fail}, 2'b10);
        chk(first_a != first_b, "R8", "lanes differ", first_a, ~first_b);
        chk(first_a != second_a, "R8", "consecutive vectors differ", second_a, ~first_a);
    endtask

    // R8: same seed gives same stream after reset
    task automatic t_repro;
        do_reset(0, 0);
        start = 1'b1;
        step(1);
        chk(op_a == first_a && op_b == first_b, "R8", "first vector reproduced",
            {op_a, op_b}, {first_a, first_b});
        step(1);
        chk(op_a == second_a, "R8", "second vector reproduced", op_a, second_a);
    endtask

    // R10: start in done ignored
    task automatic t_restart_in_done;
        start = 1'b0;
        step(int'(N + LAT) + 2);
        chk(test_done, "R10", "done reached", test_done, 1);
        start = 1'b1;
        step(3);
        chk(test_done && !test_running && !op_valid, "R10", "start ignored in done",
            {test_done, test_running, op_valid}, 3'b100);
    endtask

    // R6: both NaN, different payloads -> match
    task automatic t_nan_payload;
        do_reset(1, 0);
        start = 1'b1;
        step(int'(N + LAT) + 2);
        chk(test_done && test_pass && !test_fail, "R6", "NaN payloads treated equal",
            {test_done, test_pass, test_fail}, 3'b110);
    endtask

    // R5 R6: infinity vs NaN mismatch at exact edge
    task automatic t_inf_vs_nan;
        int k = 4;
        do_reset(3, k);
        start = 1'b1;
        step(1);
        step(k + int'(LAT) - 1);
        chk(!test_fail, "R5", "no fail before due edge (inf/NaN)", test_fail, 0);
        step(1);
        chk(test_fail, "R6", "infinity vs NaN is a mismatch", test_fail, 1);
    endtask

    // R5 R7: corrupted vector, sticky fail, no pass
    task automatic t_corrupt;
        int k = 7;
        do_reset(2, k);
        start = 1'b1;
        step(1);
        step(k + int'(LAT) - 1);
        chk(!test_fail, "R5", "no fail before due edge", test_fail, 0);
        step(1);
        chk(test_fail, "R5", "fail at edge k+LAT", test_fail, 1);
        step(int'(N) - k + 1);
        chk(test_done && test_fail && !test_pass, "R7", "sticky fail, no pass",
            {test_done, test_fail, test_pass}, 3'b110);
    endtask

    // R9: injected error during one compare cycle
    task automatic t_inject;
        int k = 10;
        do_reset(0, 0);
        start = 1'b1;
        step(1);
        step(k + int'(LAT) - 1);
        inject_err = 1'b1;
        chk(!test_fail, "R9", "no fail before injection", test_fail, 0);
        step(1);
        inject_err = 1'b0;
        chk(test_fail, "R9", "injection detected", test_fail, 1);
    endtask

    initial begin
        t_reset();
        t_clean_run();
        t_repro();
        t_restart_in_done();
        t_nan_payload();
        t_inf_vs_nan();
        t_corrupt();
        t_inject();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule